// File: doc/BRIEF.md
# Quad-I/O Serial RAM Access Engine

This block turns single read and write requests from a host port into complete transactions on a quad-I/O serial RAM that is already in four-line mode. For each accepted request it lowers chip select, sends an 8-bit opcode and a 24-bit address four bits per serial clock, adds a dummy gap on reads, and then moves one to four data bytes, again four bits per serial clock. It then releases chip select and may add trailing serial clocks.

The serial clock comes from the system clock through a programmable divider. The divisor and a clock-mode selector are sampled with each request. The mode sets what happens around the rise of chip select: a one-cycle select hold, one or two trailing clocks with the device deselected, or a clock that keeps running between transactions. The host sees ready again only when the transaction, including any trailing clocks, has finished. A one-cycle response pulse marks completion and carries the read data.

Top module: `qpsram_engine`

## Requirements
- R1: After reset, `cs_no` is 1, `sck_o` is 0, `sio_oe_o` is 0, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A read sends opcode 0xEB, high nibble first, on all four lines. It then sends the 24-bit address, most significant nibble first (six beats), and leaves 5 dummy beats. Then come 2×(len+1) data beats. `sio_oe_o` is 4'hF for the opcode and address beats and 4'h0 from the first dummy beat through the last data beat.
- R3: A write sends opcode 0x38, the same six address beats and then 2×(len+1) data beats with no dummy gap. `sio_oe_o` is 4'hF on every beat.
- R4: `req_len_i` holds the byte count minus one. Data moves lowest byte first (byte k is bits 8k+7..8k) and high nibble first within each byte. On completion of a read, `rsp_rdata_o` holds the received bytes in the same lanes, and the lanes above the count are zero.
- R5: The serial period P is `cfg_div_i` system cycles when the divisor is 2 or more, and 2 cycles when it is 0 or 1. In each beat `sck_o` is low for P − floor(P/2) cycles and then high for floor(P/2) cycles. `sio_o` changes only at beat boundaries, and read nibbles are sampled in the first high cycle of the beat.
- R6: Mode 0 (normal): after the last beat, `cs_no` stays low for one more system cycle with `sck_o` low and the lines released. The engine then goes idle.
- R7: Modes 1 and 2: `cs_no` rises right after the last beat, then 1 or 2 full serial periods run with `cs_no` high before the engine goes idle.
- R8: Mode 3 (free-running clock): `cs_no` rises right after the last beat. The engine goes idle at once, and `sck_o` keeps running at the same period, starting with a low phase, until the next request is accepted.
- R9: `req_ready_o` is 1 only while the engine is idle, never while `cs_no` is low. `rsp_valid_o` is a one-cycle pulse in the first idle cycle after each transaction.
- R10: Request fields and configuration are sampled when the request is accepted. Changing them during a transaction has no effect on that transaction.
- R11: `sio_oe_o` is either all ones or all zeros, and it is zero whenever `cs_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 32 | Write data, byte 0 in bits 7..0 |
| req_len_i | input | 2 | Byte count minus one |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_rdata_o | output | 32 | Read data, valid with the pulse |
| cfg_div_i | input | 8 | Serial clock divisor |
| cfg_mode_i | input | 2 | Clock/select mode 0..3 |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| sio_o | output | 4 | Data lines out |
| sio_oe_o | output | 4 | Data line output enables |
| sio_i | input | 4 | Data lines in |

## Verification
A behavioural model in the bench predicts chip select, serial clock, enables and line values for every system cycle of each transaction, and the bench compares them on each falling edge. The requests cover reads and writes, byte counts of one, two and four, even, odd and sub-minimum divisors, and all four modes. The odd divisor separates the high-phase length from the low-phase length. The divisors 0 and 1 show the clamp to the minimum period, and the four modes separate the hold cycle, the trailing clocks and the free-running idle clock. During each transaction the bench scrambles the request and configuration inputs, so that any late sampling shows up as a waveform mismatch. On read beats outside the data phase, random nibbles are driven in, so that a sample at the wrong beat corrupts the returned word.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;
  typedef enum logic [1:0] {
    CLK_NORMAL = 2'd0,
    CLK_TAIL1  = 2'd1,
    CLK_TAIL2  = 2'd2,
    CLK_FREE   = 2'd3
  } clk_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_HOLD,
    ST_TAIL
  } state_e;

  localparam logic [7:0] CMD_RD = 8'hEB;
  localparam logic [7:0] CMD_WR = 8'h38;
endpackage

// File: rtl/qpsram_sck_gen.sv
module qpsram_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] per_i,
  input  logic             clr_i,
  input  logic             run_i,
  output logic             wrap_o,
  output logic             rise_o,
  output logic             sck_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lo_len;

  assign lo_len = per_i - (per_i >> 1);
  assign wrap_o = (cnt_q == per_i - DIV_W'(1));
  assign rise_o = (cnt_q == lo_len);
  assign sck_o  = run_i && (cnt_q >= lo_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= wrap_o ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/qpsram_nib_mux.sv
module qpsram_nib_mux
  import qpsram_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_BYTES = 4,
  parameter int BEAT_W     = 5
) (
  input  logic [BEAT_W-1:0]       beat_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [8*DATA_BYTES-1:0] wdata_i,
  output logic [3:0]              nib_o
);
  localparam int ANIB  = ADDR_W / 4;
  localparam int HDR   = 2 + ANIB;
  localparam int NIB_N = 2 * DATA_BYTES;

  logic [3:0] anib [ANIB];
  logic [3:0] wnib [NIB_N];

  for (genvar g = 0; g < ANIB; g++) begin : g_anib
    assign anib[g] = addr_i[4*g +: 4];
  end

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_wnib
    assign wnib[2*k]   = wdata_i[8*k+4 +: 4];
    assign wnib[2*k+1] = wdata_i[8*k +: 4];
  end

  always_comb begin
    int b;
    logic [7:0] cmd;
    b     = int'(beat_i);
    cmd   = wr_i ? CMD_WR : CMD_RD;
    nib_o = '0;
    if (b == 0)                nib_o = cmd[7:4];
    else if (b == 1)           nib_o = cmd[3:0];
    else if (b < HDR)          nib_o = anib[HDR-1-b];
    else if (b - HDR < NIB_N)  nib_o = wnib[b-HDR];
  end
endmodule

// File: rtl/qpsram_rx_cap.sv
module qpsram_rx_cap #(
  parameter int DATA_BYTES = 4,
  parameter int IDX_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [3:0]              sio_i,
  output logic [8*DATA_BYTES-1:0] rdata_o
);
  localparam int NIB_N = 2 * DATA_BYTES;

  logic [3:0] slot_q [NIB_N];

  for (genvar j = 0; j < NIB_N; j++) begin : g_slot
    // even slot = high nibble of byte j/2
    localparam int POS = 8 * (j / 2) + ((j % 2 == 0) ? 4 : 0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           slot_q[j] <= '0;
      else if (clr_i)                        slot_q[j] <= '0;
      else if (en_i && idx_i == IDX_W'(j))   slot_q[j] <= sio_i;
    end
    assign rdata_o[POS +: 4] = slot_q[j];
  end
endmodule

// File: rtl/qpsram_engine.sv
module qpsram_engine
  import qpsram_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int ADDR_W     = 24,
  parameter int DATA_BYTES = 4,
  parameter int RD_DUMMY   = 5
) (
  input  logic                                              clk_i,
  input  logic                                              rst_ni,
  input  logic                                              req_valid_i,
  output logic                                              req_ready_o,
  input  logic                                              req_write_i,
  input  logic [ADDR_W-1:0]                                 req_addr_i,
  input  logic [8*DATA_BYTES-1:0]                           req_wdata_i,
  input  logic [((DATA_BYTES>1)?$clog2(DATA_BYTES):1)-1:0]  req_len_i,
  output logic                                              rsp_valid_o,
  output logic [8*DATA_BYTES-1:0]                           rsp_rdata_o,
  input  logic [DIV_W-1:0]                                  cfg_div_i,
  input  logic [1:0]                                        cfg_mode_i,
  output logic                                              sck_o,
  output logic                                              cs_no,
  output logic [3:0]                                        sio_o,
  output logic [3:0]                                        sio_oe_o,
  input  logic [3:0]                                        sio_i
);
  localparam int LEN_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam int HDR       = 2 + ADDR_W / 4;
  localparam int RD_START  = HDR + RD_DUMMY;
  localparam int MAX_BEATS = RD_START + 2 * DATA_BYTES;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
  localparam int NIB_N     = 2 * DATA_BYTES;
  localparam int IDX_W     = (NIB_N > 1) ? $clog2(NIB_N) : 1;

  state_e                  state_q;
  logic [BEAT_W-1:0]       beat_q;
  logic                    tail_q;
  logic                    run_q;
  logic                    done_q;
  logic                    wr_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [8*DATA_BYTES-1:0] wdata_q;
  logic [LEN_W-1:0]        len_q;
  logic [DIV_W-1:0]        per_q;
  clk_mode_e               mode_q;

  logic                    accept;
  logic                    run;
  logic                    wrap;
  logic                    rise;
  logic [BEAT_W-1:0]       data_start;
  logic [BEAT_W-1:0]       last_beat;
  logic [BEAT_W-1:0]       data_idx;
  logic                    tail_last;
  logic                    oe;
  logic [3:0]              nib;
  logic                    cap_en;

  assign accept      = req_valid_i && req_ready_o;
  assign req_ready_o = (state_q == ST_IDLE);
  assign run         = (state_q == ST_XFER) || (state_q == ST_TAIL) ||
                       ((state_q == ST_IDLE) && run_q);
  assign data_start  = wr_q ? BEAT_W'(HDR) : BEAT_W'(RD_START);
  assign last_beat   = data_start + BEAT_W'({len_q, 1'b1});
  assign data_idx    = beat_q - BEAT_W'(RD_START);
  assign tail_last   = (mode_q == CLK_TAIL2);

  assign cs_no       = !((state_q == ST_XFER) || (state_q == ST_HOLD));
  assign oe          = (state_q == ST_XFER) && (wr_q || beat_q < BEAT_W'(HDR));
  assign sio_oe_o    = {4{oe}};
  assign sio_o       = oe ? nib : 4'h0;
  assign rsp_valid_o = done_q;
  assign cap_en      = (state_q == ST_XFER) && !wr_q && rise &&
                       (beat_q >= BEAT_W'(RD_START));

  qpsram_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .per_i  (per_q),
    .clr_i  (accept),
    .run_i  (run),
    .wrap_o (wrap),
    .rise_o (rise),
    .sck_o  (sck_o)
  );

  qpsram_nib_mux #(
    .ADDR_W     (ADDR_W),
    .DATA_BYTES (DATA_BYTES),
    .BEAT_W     (BEAT_W)
  ) u_mux (
    .beat_i  (beat_q),
    .wr_i    (wr_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .nib_o   (nib)
  );

  qpsram_rx_cap #(
    .DATA_BYTES (DATA_BYTES),
    .IDX_W      (IDX_W)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .en_i    (cap_en),
    .idx_i   (data_idx[IDX_W-1:0]),
    .sio_i   (sio_i),
    .rdata_o (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      len_q   <= '0;
      per_q   <= DIV_W'(2);
      mode_q  <= CLK_NORMAL;
    end else if (accept) begin
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      len_q   <= req_len_i;
      per_q   <= (cfg_div_i <= DIV_W'(1)) ? DIV_W'(2) : cfg_div_i;
      mode_q  <= clk_mode_e'(cfg_mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      tail_q  <= 1'b0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_XFER;
          beat_q  <= '0;
          run_q   <= 1'b0;
        end
        ST_XFER: if (wrap) begin
          if (beat_q == last_beat) begin
            tail_q <= 1'b0;
            unique case (mode_q)
              CLK_NORMAL: state_q <= ST_HOLD;
              CLK_TAIL1, CLK_TAIL2: state_q <= ST_TAIL;
              CLK_FREE: begin
                state_q <= ST_IDLE;
                run_q   <= 1'b1;
                done_q  <= 1'b1;
              end
            endcase
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        ST_HOLD: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        ST_TAIL: if (wrap) begin
          if (tail_q == tail_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            tail_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/qpsram_engine_chk.sv
module qpsram_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       cs_no,
  input logic       sck_o,
  input logic [3:0] sio_oe_o
);
  assert_ready_only_deselected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);

  assert_accept_selects_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!cs_no && !req_ready_o));

  assert_rsp_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  assert_oe_all_or_none_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sio_oe_o) == 0) || ($countones(sio_oe_o) == 4));

  assert_oe_off_deselected_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sio_oe_o == 4'h0));

  assert_cs_rise_sck_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> !sck_o);
endmodule

bind qpsram_engine qpsram_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .cs_no       (cs_no),
  .sck_o       (sck_o),
  .sio_oe_o    (sio_oe_o)
);

// File: tb/qpsram_engine_bench.sv
module qpsram_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [1:0]  req_len_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [7:0]  cfg_div_i = 8'd4;
  logic [1:0]  cfg_mode_i = '0;
  logic        sck_o;
  logic        cs_no;
  logic [3:0]  sio_o;
  logic [3:0]  sio_oe_o;
  logic [3:0]  sio_i = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  bit         q_cs[$];
  bit         q_sck[$];
  bit         q_oe[$];
  logic [3:0] q_sio[$];
  logic [3:0] q_din[$];
  string      q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qpsram_engine u_qpsram_engine (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_len_i   (req_len_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .cfg_div_i   (cfg_div_i),
    .cfg_mode_i  (cfg_mode_i),
    .sck_o       (sck_o),
    .cs_no       (cs_no),
    .sio_o       (sio_o),
    .sio_oe_o    (sio_oe_o),
    .sio_i       (sio_i)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic push(bit cs, bit sck, bit oe, logic [3:0] sio, logic [3:0] din, string req);
    q_cs.push_back(cs);
    q_sck.push_back(sck);
    q_oe.push_back(oe);
    q_sio.push_back(sio);
    q_din.push_back(din);
    q_req.push_back(req);
  endtask

  // Behavioural expectation of every system cycle after acceptance
  task automatic build(bit wr, logic [23:0] addr, logic [31:0] wdata, int len,
                       int div, int mode, logic [31:0] rval);
    int p;
    int lo;
    int hdr_n;
    logic [7:0] cmd;
    logic [3:0] nibs[$];
    p   = (div <= 1) ? 2 : div;
    lo  = p - p / 2;
    cmd = wr ? 8'h38 : 8'hEB;
    nibs.push_back(cmd[7:4]);
    nibs.push_back(cmd[3:0]);
    for (int i = 5; i >= 0; i--) nibs.push_back(addr[4*i +: 4]);
    if (!wr) for (int i = 0; i < 5; i++) nibs.push_back(4'h0);
    hdr_n = nibs.size();
    for (int k = 0; k <= len; k++) begin
      logic [7:0] byt;
      byt = wr ? wdata[8*k +: 8] : rval[8*k +: 8];
      nibs.push_back(byt[7:4]);
      nibs.push_back(byt[3:0]);
    end
    for (int b = 0; b < nibs.size(); b++) begin
      bit oe;
      bit is_data;
      string tag;
      oe      = wr || (b < 8);
      is_data = (b >= hdr_n);
      tag     = is_data ? "R4" : (wr ? "R3" : "R2");
      for (int c = 0; c < p; c++)
        push(1'b0, c >= lo, oe, oe ? nibs[b] : 4'h0,
             (is_data && !wr) ? nibs[b] : 4'($urandom), tag);
    end
    if (mode == 0) push(1'b0, 1'b0, 1'b0, 4'h0, 4'($urandom), "R6");
    if (mode == 1 || mode == 2)
      for (int t = 0; t < mode; t++)
        for (int c = 0; c < p; c++) push(1'b1, c >= lo, 1'b0, 4'h0, 4'($urandom), "R7");
  endtask

  task automatic run(bit wr, logic [23:0] addr, logic [31:0] wdata, int len,
                     int div, int mode, logic [31:0] rval);
    int p;
    int lo;
    logic [31:0] exp_rd;
    p  = (div <= 1) ? 2 : div;
    lo = p - p / 2;
    exp_rd = '0;
    for (int k = 0; k <= len; k++) exp_rd[8*k +: 8] = rval[8*k +: 8];
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_write_i = wr;
    req_addr_i  = addr;
    req_wdata_i = wdata;
    req_len_i   = 2'(len);
    cfg_div_i   = 8'(div);
    cfg_mode_i  = 2'(mode);
    req_valid_i = 1'b1;
    build(wr, addr, wdata, len, div, mode, rval);
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
    // R10: scramble every sampled input while the transaction runs
    req_write_i = ~wr;
    req_addr_i  = ~addr;
    req_wdata_i = ~wdata;
    req_len_i   = ~2'(len);
    cfg_div_i   = 8'(div + 3);
    cfg_mode_i  = ~2'(mode);
    while (q_cs.size() > 0) begin
      bit cs;
      bit sck;
      bit oe;
      logic [3:0] sio;
      logic [3:0] din;
      string req;
      @(negedge clk);
      cs  = q_cs.pop_front();
      sck = q_sck.pop_front();
      oe  = q_oe.pop_front();
      sio = q_sio.pop_front();
      din = q_din.pop_front();
      req = q_req.pop_front();
      check(cs_no == cs, req, "cs_no", cs_no, cs);
      check(sck_o == sck, (req == "R7") ? "R7" : "R5", "sck_o", sck_o, sck);
      check(sio_oe_o == {4{oe}}, "R11", "sio_oe_o", sio_oe_o, {4{oe}});
      check(sio_o == sio, req, "sio_o", sio_o, sio);
      check(!req_ready_o, "R9", "ready during transfer", req_ready_o, 0);
      sio_i = din;
    end
    @(negedge clk);
    check(req_ready_o, "R9", "ready after transfer", req_ready_o, 1);
    check(rsp_valid_o, "R9", "rsp_valid pulse", rsp_valid_o, 1);
    check(cs_no, "R9", "cs_no idle", cs_no, 1);
    if (!wr) check(rsp_rdata_o == exp_rd, "R4,R10", "rsp_rdata_o", rsp_rdata_o, exp_rd);
    if (mode == 3) begin
      for (int i = 0; i < 2 * p + 1; i++) begin
        if (i > 0) @(negedge clk);
        check(sck_o == ((i % p) >= lo), "R8", "idle sck_o", sck_o, (i % p) >= lo);
        check(cs_no, "R8", "idle cs_no", cs_no, 1);
      end
    end else begin
      @(negedge clk);
      check(!rsp_valid_o, "R9", "rsp_valid single cycle", rsp_valid_o, 0);
      check(!sck_o, "R6", "idle sck_o", sck_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_no == 1'b1, "R1", "cs_no", cs_no, 1);
    check(sck_o == 1'b0, "R1", "sck_o", sck_o, 0);
    check(sio_oe_o == 4'h0, "R1", "sio_oe_o", sio_oe_o, 0);
    check(req_ready_o == 1'b1, "R1", "req_ready_o", req_ready_o, 1);
    check(rsp_valid_o == 1'b0, "R1", "rsp_valid_o", rsp_valid_o, 0);
    rst_ni = 1'b1;
    // R2 R4 R5 R6: four-byte read, even divisor, normal mode
    run(1'b0, 24'h12_3456, 32'h0, 3, 4, 0, 32'hA1B2_C3D4);
    // R3 R7: four-byte write, divisor 2, one tail clock
    run(1'b1, 24'hAB_CDEF, 32'h8765_4321, 3, 2, 1, 32'h0);
    // R5 R7: single-byte read, odd divisor, two tail clocks
    run(1'b0, 24'h00_00FF, 32'h0, 0, 3, 2, 32'h5A5A_5A3C);
    // R5 R8: two-byte write, divisor 0 clamps, free clock
    run(1'b1, 24'hF0_0F00, 32'h0000_BEEF, 1, 0, 3, 32'h0);
    // R5 R8: read right after free-clock idle, divisor 1
    run(1'b0, 24'h7F_FFFF, 32'h0, 1, 1, 3, 32'h1234_9E71);
    // R3 R6: single-byte write, odd divisor 5
    run(1'b1, 24'h80_0001, 32'hFFFF_FF96, 0, 5, 0, 32'h0);
    // R4 R7: two-byte read, divisor 6
    run(1'b0, 24'h33_3333, 32'h0, 1, 6, 1, 32'hC0DE_F00D);
    summary();
  end
endmodule